// File: doc/BRIEF.md
# Fault input conditioner

This block prepares up to four asynchronous fault pins for use by a timer. Each pin is first aligned to the timer clock by a short flop chain. It then passes through an optional digital glitch filter. When the conditioned level rises from inactive to active, a sticky per-channel fault flag is set. Each channel has its own polarity setting, so a channel can treat either a high pin or a low pin as its fault level.

The glitch filter belongs to the channel and runs on that channel's own counter. The counter starts whenever the synchronized level differs from the level the filter last accepted. It restarts whenever the input goes back before the new level has been accepted. All channels share one 4-bit filter value, which sets how long a new level must stay steady.

The time from a pin edge to the flag is exact in both modes. With the filter active it depends on the filter value. With the filter bypassed it is fixed. Software clears a flag with a one-cycle pulse on that channel's clear input.

Top module: `fault_cond`

## Requirements
- R1: While `fault_mode` is 2'b00, no fault flag is set on any channel, whatever the pins do.
- R2: A channel whose `ch_en` bit is 0 never sets its flag.
- R3: The filter is bypassed when `filt_val` is 0 or when the channel's `filt_en` bit is 0. In bypass, a pin change to the active level that is sampled at rising edge 1 sets the flag at rising edge 3.
- R4: With `filt_en`=1 and `filt_val`=F (F from 1 to 15), a pin change to the active level that is sampled at rising edge 1 and held sets the flag at rising edge 4+F.
- R5: With the filter active and value F, a pin at the active level for W consecutive rising edges is discarded as a glitch when W is F or less. It is accepted and sets the flag when W is F+1 or more.
- R6: `active_low`=0 makes a high pin the fault level, and `active_low`=1 makes a low pin the fault level. A pin change to the non-fault level never sets the flag.
- R7: A set flag stays at 1 until a one-cycle `flag_clr` pulse on its channel. The flag then reads 0 after that rising edge.
- R8: If a new detection and a clear fall on the same rising edge of a channel, the flag is 1 after that edge.
- R9: During reset all flags are 0. After reset, with every pin at its inactive level, no flag appears.
- R10: A flag is set only on an inactive-to-active change of the conditioned level. A pin held active after a clear does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 4 | Raw asynchronous fault pins, one per channel |
| fault_mode | input | 2 | Global fault mode; 2'b00 disables all detection |
| ch_en | input | 4 | Per-channel detection enable |
| filt_en | input | 4 | Per-channel glitch filter enable |
| active_low | input | 4 | Per-channel polarity; 1 means a low pin is a fault |
| filt_val | input | 4 | Shared filter value in clock cycles; 0 bypasses the filter |
| flag_clr | input | 4 | Per-channel one-cycle flag clear pulse |
| fault_flag | output | 4 | Sticky per-channel fault flags |

## Verification
Two functions can fall on the same rising edge of a channel: the edge detector setting the flag and a software clear. The bench provokes this by raising a bypassed pin while its flag is already set. It then drives the clear during the cycle before the third rising edge, which is the edge that sets the flag. The flag must read 1 after that edge, and the behavioural reference model agrees with this on every clock. A plain clear with the pin held active must leave the flag at 0.

// File: rtl/fault_cond_pkg.sv
package fault_cond_pkg;

   // Per-channel static setting, gathered for readability in the top.
   typedef struct packed {
      logic enable;
      logic filt_on;
      logic inv;
   } fc_chan_cfg_t;

   // Saturating increment for counters of any width.
   function automatic logic [31:0] fc_sat_inc(input logic [31:0] v, input logic [31:0] vmax);
      return (v >= vmax) ? vmax : v + 32'd1;
   endfunction

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_async;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fault_filter.sv
module fault_filter
   import fault_cond_pkg::*;
#(
   parameter int unsigned VAL_W = 4,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [VAL_W-1:0] limit,
   output logic             level
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_q;
   logic             lvl_q;
   logic             pending;
   logic             ripe;
   logic [CNT_W-1:0] run_nxt;

   assign pending = (din != lvl_q);
   assign ripe    = (run_q >= CNT_W'(limit));
   assign run_nxt = CNT_W'(fc_sat_inc(32'(run_q), 32'(CNT_MAX)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (!pending) begin
         run_q <= '0;
      end else if (ripe) begin
         lvl_q <= din;
         run_q <= '0;
      end else begin
         run_q <= run_nxt;
      end
   end

   assign level = lvl_q;
endmodule

// File: rtl/fault_flag_det.sv
module fault_flag_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic arm,
   input  logic clr,
   output logic flag
);
   logic prev_q;
   logic flag_q;
   logic hit;

   assign hit = arm & level & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= level;
         flag_q <= hit | (flag_q & ~clr);
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/fault_cond.sv
module fault_cond
   import fault_cond_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned VAL_W       = 4,
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_FILTER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] fault_pin,
   input  logic [1:0]        fault_mode,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] filt_en,
   input  logic [NUM_CH-1:0] active_low,
   input  logic [VAL_W-1:0]  filt_val,
   input  logic [NUM_CH-1:0] flag_clr,
   output logic [NUM_CH-1:0] fault_flag
);
   localparam int unsigned MIN_CNT_W = VAL_W + 1;

   initial begin
      if (NUM_CH < 1)            $fatal(1, "fault_cond: NUM_CH must be at least 1");
      if (SYNC_STAGES < 1)       $fatal(1, "fault_cond: SYNC_STAGES must be at least 1");
      if (CNT_W < MIN_CNT_W)     $fatal(1, "fault_cond: CNT_W too narrow for VAL_W");
   end

   logic              mode_on;
   logic              val_zero;
   logic [NUM_CH-1:0] sync_lvl;
   logic [NUM_CH-1:0] filt_lvl;
   logic [NUM_CH-1:0] det_lvl;

   assign mode_on  = (fault_mode != 2'b00);
   assign val_zero = (filt_val == '0);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         fc_chan_cfg_t cfg;
         logic         pin_pol;

         assign cfg     = '{enable: ch_en[ch], filt_on: filt_en[ch], inv: active_low[ch]};
         assign pin_pol = fault_pin[ch] ^ cfg.inv;

         fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pin_pol),
            .q_sync  (sync_lvl[ch])
         );

         if (HAS_FILTER) begin : g_filt
            fault_filter #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_filt (
               .clk   (clk),
               .rst_n (rst_n),
               .din   (sync_lvl[ch]),
               .limit (filt_val),
               .level (filt_lvl[ch])
            );
            assign det_lvl[ch] = (val_zero | ~cfg.filt_on) ? sync_lvl[ch] : filt_lvl[ch];
         end else begin : g_nofilt
            assign filt_lvl[ch] = sync_lvl[ch];
            assign det_lvl[ch]  = sync_lvl[ch];
         end

         fault_flag_det u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .level (det_lvl[ch]),
            .arm   (mode_on & cfg.enable),
            .clr   (flag_clr[ch]),
            .flag  (fault_flag[ch])
         );
      end
   endgenerate
endmodule

// File: rtl/fault_cond_chk.sv
module fault_cond_chk #(
   parameter int unsigned NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fault_mode,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] flag_clr,
   input logic [NUM_CH-1:0] fault_flag,
   input logic [NUM_CH-1:0] sync_lvl,
   input logic [NUM_CH-1:0] filt_lvl
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_a
         AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[i]) |-> $past(fault_mode != 2'b00)); // R1
         AST_CHAN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[i]) |-> $past(ch_en[i])); // R2
         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_flag[i] && !flag_clr[i]) |=> fault_flag[i]); // R7
         AST_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_flag[i]) |-> $past(flag_clr[i])); // R7
         AST_FILTER_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(filt_lvl[i]) |-> (filt_lvl[i] == $past(sync_lvl[i]))); // R5
      end
   endgenerate
endmodule

bind fault_cond fault_cond_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fault_mode (fault_mode),
   .ch_en      (ch_en),
   .flag_clr   (flag_clr),
   .fault_flag (fault_flag),
   .sync_lvl   (sync_lvl),
   .filt_lvl   (filt_lvl)
);

// File: tb/fault_cond_test.sv
module fault_cond_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] fault_pin = '0;
   logic [1:0]     fault_mode = 2'b01;
   logic [NCH-1:0] ch_en = '1;
   logic [NCH-1:0] filt_en = '1;
   logic [NCH-1:0] active_low = '0;
   logic [3:0]     filt_val = '0;
   logic [NCH-1:0] flag_clr = '0;
   logic [NCH-1:0] fault_flag;

   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R9";
   bit    done = 1'b0;

   fault_cond uut (
      .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .fault_mode(fault_mode),
      .ch_en(ch_en), .filt_en(filt_en), .active_low(active_low), .filt_val(filt_val),
      .flag_clr(flag_clr), .fault_flag(fault_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference model
   logic [NCH-1:0] hist[$];
   int             m_cnt[NCH];
   bit             m_acc[NCH];
   bit             m_prv[NCH];
   logic [NCH-1:0] m_flag;
   logic [NCH-1:0] s_old;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{4'b0, 4'b0};
         m_flag = '0;
         for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0; m_acc[c] = 0; m_prv[c] = 0;
         end
      end else begin
         s_old = hist[0];
         for (int c = 0; c < NCH; c++) begin
            bit byp, lv, st;
            byp = (filt_val == 0) || !filt_en[c];
            lv  = byp ? s_old[c] : m_acc[c];
            st  = (fault_mode != 2'b00) && ch_en[c] && lv && !m_prv[c];
            m_flag[c] = st | (m_flag[c] & ~flag_clr[c]);
            m_prv[c] = lv;
            if (s_old[c] != m_acc[c]) begin
               if (m_cnt[c] >= int'(filt_val)) begin
                  m_acc[c] = s_old[c]; m_cnt[c] = 0;
               end else if (m_cnt[c] < 31) m_cnt[c]++;
            end else m_cnt[c] = 0;
         end
         hist.push_back(fault_pin ^ active_low);
         void'(hist.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (fault_flag !== m_flag) begin
            n_err++;
            $display("FAIL %s model compare: actual %b expected %b at %0t", cur_req, fault_flag, m_flag, $time);
         end
      end
   end

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic set_pin(int c, bit active);
      fault_pin[c] = active ? ~active_low[c] : active_low[c];
   endtask

   task automatic clear_ch(int c);
      flag_clr[c] = 1'b1; tick(); flag_clr[c] = 1'b0;
   endtask

   task automatic run_latency(int c, int exp, string req);
      int lat;
      lat = -1;
      set_pin(c, 0); tick(20); clear_ch(c); tick(2);
      set_pin(c, 1);
      for (int n = 1; n <= 40; n++) begin
         tick();
         if (fault_flag[c] && lat < 0) lat = n;
      end
      check(req, lat, exp, $sformatf("latency ch%0d F=%0d", c, filt_val));
   endtask

   task automatic run_pulse(int c, int w, int exp, string req);
      set_pin(c, 0); tick(20); clear_ch(c); tick(2);
      set_pin(c, 1); tick(w); set_pin(c, 0); tick(25);
      check(req, int'(fault_flag[c]), exp, $sformatf("pulse ch%0d W=%0d F=%0d", c, w, filt_val));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      // R9: reset state
      tick(4);
      check("R9", int'(fault_flag), 0, "flags during reset");
      rst_n = 1'b1;
      tick(12);
      check("R9", int'(fault_flag), 0, "flags after reset");

      // R3: bypass latency, zero value and filter disabled
      cur_req = "R3";
      filt_val = 4'd0;
      run_latency(0, 3, "R3");
      filt_val = 4'd7; filt_en[0] = 1'b0;
      run_latency(0, 3, "R3");

      // R4: filtered latency
      cur_req = "R4";
      filt_val = 4'd1;  run_latency(2, 5, "R4");
      filt_val = 4'd5;  run_latency(2, 9, "R4");
      filt_val = 4'd15; run_latency(2, 19, "R4");

      // R8: detection and clear on the same edge (ch0 bypassed, flag still set)
      cur_req = "R8";
      check("R8", int'(fault_flag[0]), 1, "flag before collision");
      set_pin(0, 0); tick(10);
      set_pin(0, 1); tick(2);
      flag_clr[0] = 1'b1; tick(); flag_clr[0] = 1'b0;
      check("R8", int'(fault_flag[0]), 1, "flag after set and clear collide");

      // R7 and R10: clear with pin held active
      cur_req = "R7";
      clear_ch(0);
      check("R7", int'(fault_flag[0]), 0, "flag after clear");
      cur_req = "R10";
      tick(20);
      check("R10", int'(fault_flag[0]), 0, "no re-set with pin held");

      // R5: glitch rejection at the boundary
      cur_req = "R5";
      filt_val = 4'd3;
      run_pulse(1, 3, 0, "R5");
      run_pulse(1, 4, 1, "R5");
      filt_val = 4'd1;
      run_pulse(1, 1, 0, "R5");
      run_pulse(1, 2, 1, "R5");

      // R6: active-low channel
      cur_req = "R6";
      filt_val = 4'd0;
      active_low[3] = 1'b1; fault_pin[3] = 1'b1;
      run_latency(3, 3, "R6");
      check("R6", int'(fault_pin[3]), 0, "active-low pin driven low");
      set_pin(3, 0); tick(5); clear_ch(3); tick(20);
      check("R6", int'(fault_flag[3]), 0, "rise to non-fault level ignored");

      // R2: channel disabled
      cur_req = "R2";
      ch_en[1] = 1'b0;
      run_pulse(1, 10, 0, "R2");
      ch_en[1] = 1'b1;

      // R1: global mode off
      cur_req = "R1";
      fault_mode = 2'b00;
      for (int c = 0; c < NCH; c++) begin set_pin(c, 0); end
      tick(20);
      for (int c = 0; c < NCH; c++) begin clear_ch(c); end
      for (int c = 0; c < NCH; c++) begin set_pin(c, 1); end
      tick(25);
      for (int c = 0; c < NCH; c++) begin set_pin(c, 0); end
      tick(25);
      check("R1", int'(fault_flag), 0, "flags with mode off");
      fault_mode = 2'b11;
      run_latency(2, 3, "R1");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule